// File: doc/BRIEF.md
# Clickless Keyed Sidetone Generator

This block turns a single key line into an audio tone suitable for a serial audio DAC running at 48 kHz. On every sample enable it reads a signed 16-bit sine value from a table holding exactly one tone period, scales it by a raised-cosine gain read from a 512-step table, and forms a 32-bit word for the DAC. The gain index climbs by one per sample while the key is held and falls by one per sample after release, so the tone fades in and out over roughly 10.7 ms instead of switching hard, which would be heard as a click.

The tone period is a whole number of samples. The nominal table holds 80 entries (600 Hz at 48 kHz), and a select input picks a 79-entry or an 81-entry table instead (about 607.6 Hz and 592.6 Hz). Because every table holds an exact period, there is no phase truncation and no jitter. The phase index returns to zero whenever the gain reaches zero, so every keyed tone starts at zero phase.

The DAC word is sent MSB first in two 32-bit slots per 64-clock frame, the same sample in the left and in the right slot. A 6-bit frame position counter is brought out so that the surrounding logic can derive the bit and word clocks. The sample enable is expected once per frame and is best placed at frame position 63, so that a fresh word is loaded at the next frame start.

Top module: `sidetone_gen`

## Requirements
- R1: While reset is held, `ser_out` is 0 and `frame_pos` is 0. The stored sample word and both table indices clear to 0, so every slot carries an all-zero word until the key is first pressed.
- R2: `frame_pos` increases by one on every clock and wraps from 63 to 0.
- R3: The stored word is loaded into the shifter on each edge where `frame_pos[4:0]` is 0, then shifted out MSB first. Its MSB is on `ser_out` while `frame_pos` is 1 (left slot) and 33 (right slot), and its LSB is there at 32 and at 0. Both slots of a frame carry the same word.
- R4: The slot word is the signed 32-bit product of envelope and sine, bits [30:0], followed by a 0 as the LSB. This equals twice the product, and the LSB of each slot is always 0.
- R5: Sine entry i of a table of length N is round(32767 * sin(2*pi*i/N)) within +/-2, and entry 0 is exactly 0.
- R6: `period_sel` codes the table length: 2'b00 and 2'b11 give 80, 2'b01 gives 79, and 2'b10 gives 81. The phase index advances by one per sample enable. From N-1, or from any larger value, it goes to 0.
- R7: With `key_in` high, the envelope index rises by one per sample enable and holds at 511. Envelope entry k is round(32766 * (1 - cos(pi*k/511)) / 2) within +/-2, exactly 0 at k = 0 and exactly 32766 at k = 511.
- R8: With `key_in` low, the envelope index falls by one per sample enable and holds at 0.
- R9: When a sample enable leaves the envelope index at 0, the phase index is set to 0. Every tone therefore starts at zero phase, and the phase stays at 0 while the block is silent.
- R10: On clocks without `smp_en`, neither index and not the stored word changes, so later frames repeat the last word.
- R11: The word stored on an enabled edge is computed from the indices as they stood before that edge's update, and it reaches the serial output in the frame that starts next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | 1 | Key line; high sounds the tone |
| smp_en | input | 1 | One-cycle sample enable at the 48 kHz rate |
| period_sel | input | 2 | Tone table length select (80 / 79 / 81 samples) |
| ser_out | output | 1 | Serial DAC data, MSB first, two 32-bit slots per frame |
| frame_pos | output | 6 | Bit position inside the 64-clock frame |

## Verification
The key is tried in four patterns: silence after reset, a full fade-in held at full gain, a full fade-out back to silence, and a partial fade-in under each of the shorter and longer table lengths. Silence must give exact zero words and shows whether the phase restart and the index order are right. The full-gain stretch must give words that are exact multiples of 32766, which tells the exact end point of the envelope apart from a value that is merely close. The 79- and 81-sample runs, compared with a real-valued model, expose a wrong wrap point or a wrong table, and a stretch with the sample enable held low checks that the frames repeat without change.

// File: rtl/sidetone_pkg.sv
package sidetone_pkg;

   // Fixed-point angle constants, 30 fractional bits
   localparam longint ONE_Q30     = 64'sd1073741824;
   localparam longint PI_Q30      = 64'sd3373259426;
   localparam longint HALF_PI_Q30 = 64'sd1686629713;
   localparam longint TWO_PI_Q30  = 64'sd6746518852;

   // sin(a) for a in [0, pi/2], Q30 in and out, odd Taylor terms up to a^17
   function automatic longint sin_q30(input longint a);
      longint term;
      longint acc;
      term = a;
      acc  = a;
      for (int k = 1; k < 9; k++) begin
         term = -((((term * a) >>> 30) * a) >>> 30) / longint'((2 * k) * (2 * k + 1));
         acc  = acc + term;
      end
      if (acc < 0) acc = 0;
      return acc;
   endfunction

   // Rounded amplitude * sin(2*pi*idx/len)
   function automatic int sine_code(input int idx, input int len, input int amp);
      longint ang;
      longint mag;
      bit     neg;
      ang = (TWO_PI_Q30 * longint'(idx)) / longint'(len);
      neg = 1'b0;
      if (ang >= PI_Q30) begin
         neg = 1'b1;
         ang = ang - PI_Q30;
      end
      if (ang > HALF_PI_Q30) ang = PI_Q30 - ang;
      mag = (sin_q30(ang) * longint'(amp) + (ONE_Q30 >>> 1)) >>> 30;
      if (mag > longint'(amp)) mag = longint'(amp);
      return neg ? -int'(mag) : int'(mag);
   endfunction

   // Rounded top * (1 - cos(pi*k/(steps-1))) / 2 = top * sin^2(pi*k/(2*(steps-1)))
   function automatic int env_code(input int k, input int steps, input int top);
      longint ang;
      longint s;
      longint sq;
      if (k <= 0) return 0;
      if (k >= steps - 1) return top;
      ang = (HALF_PI_Q30 * longint'(k)) / longint'(steps - 1);
      s   = sin_q30(ang);
      sq  = (s * s) >>> 30;
      return int'((sq * longint'(top) + (ONE_Q30 >>> 1)) >>> 30);
   endfunction

endpackage

// File: rtl/sidetone_sine_rom.sv
module sidetone_sine_rom
   import sidetone_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int BASE_LEN = 80,
   parameter int AMP      = 32767,
   parameter int IDX_W    = 7
) (
   input  logic [1:0]               len_sel,
   input  logic [IDX_W-1:0]         idx,
   output logic signed [DATA_W-1:0] sample,
   output logic [IDX_W-1:0]         last_idx
);

   localparam int NUM_VAR = 3;
   localparam int DEPTH   = 2 ** IDX_W;

   if (BASE_LEN < 8 || BASE_LEN + 1 > DEPTH || AMP >= 2 ** (DATA_W - 1)) begin : g_bad_cfg
      $error("sidetone_sine_rom: table length or amplitude does not fit");
   end

   logic signed [DATA_W-1:0] var_sample [NUM_VAR];
   logic [IDX_W-1:0]         var_last   [NUM_VAR];

   // Variant 0: nominal length, 1: one shorter, 2: one longer
   for (genvar v = 0; v < NUM_VAR; v++) begin : g_var
      localparam int LEN = (v == 0) ? BASE_LEN : ((v == 1) ? BASE_LEN - 1 : BASE_LEN + 1);
      logic signed [DATA_W-1:0] tbl [DEPTH];
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         localparam int CODE = (g < LEN) ? sine_code(g, LEN, AMP) : 0;
         assign tbl[g] = DATA_W'(CODE);
      end
      assign var_sample[v] = tbl[idx];
      assign var_last[v]   = IDX_W'(LEN - 1);
   end

   always_comb begin
      case (len_sel)
         2'b01: begin
            sample   = var_sample[1];
            last_idx = var_last[1];
         end
         2'b10: begin
            sample   = var_sample[2];
            last_idx = var_last[2];
         end
         default: begin
            sample   = var_sample[0];
            last_idx = var_last[0];
         end
      endcase
   end

endmodule

// File: rtl/sidetone_env_rom.sv
module sidetone_env_rom
   import sidetone_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ENV_W  = 9,
   parameter int TOP    = 32766
) (
   input  logic [ENV_W-1:0]         idx,
   output logic signed [DATA_W-1:0] gain
);

   localparam int STEPS = 2 ** ENV_W;

   if (ENV_W < 2 || TOP >= 2 ** (DATA_W - 1)) begin : g_bad_cfg
      $error("sidetone_env_rom: envelope size or top value does not fit");
   end

   logic signed [DATA_W-1:0] tbl [STEPS];

   for (genvar g = 0; g < STEPS; g++) begin : g_ent
      localparam int CODE = env_code(g, STEPS, TOP);
      assign tbl[g] = DATA_W'(CODE);
   end

   assign gain = tbl[idx];

endmodule

// File: rtl/sidetone_ctrl.sv
module sidetone_ctrl #(
   parameter int ENV_W = 9,
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_en,
   input  logic             key,
   input  logic [IDX_W-1:0] last_idx,
   output logic [ENV_W-1:0] env_idx,
   output logic [IDX_W-1:0] ph_idx
);

   localparam logic [ENV_W-1:0] ENV_MAX = '1;

   logic [ENV_W-1:0] env_nxt;
   logic [IDX_W-1:0] ph_adv;
   logic [IDX_W-1:0] ph_nxt;

   always_comb begin
      if (key) env_nxt = (env_idx == ENV_MAX) ? ENV_MAX : env_idx + ENV_W'(1);
      else     env_nxt = (env_idx == '0) ? '0 : env_idx - ENV_W'(1);
      ph_adv = (ph_idx >= last_idx) ? '0 : ph_idx + IDX_W'(1);
      ph_nxt = (env_nxt == '0) ? '0 : ph_adv;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         env_idx <= '0;
         ph_idx  <= '0;
      end else if (smp_en) begin
         env_idx <= env_nxt;
         ph_idx  <= ph_nxt;
      end
   end

   // R7: attack steps up by one
   a_r7_attack_step: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && key && env_idx != ENV_MAX) |=> env_idx == $past(env_idx) + ENV_W'(1));
   // R7: full gain holds while keyed
   a_r7_attack_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && key && env_idx == ENV_MAX) |=> env_idx == ENV_MAX);
   // R8: release steps down by one
   a_r8_release_step: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && !key && env_idx != '0) |=> env_idx == $past(env_idx) - ENV_W'(1));
   // R9: phase restarts once the gain is back at zero
   a_r9_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && !key && env_idx <= ENV_W'(1)) |=> ph_idx == '0);
   // R6: phase stays inside the selected table after a sample
   a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      smp_en |=> ph_idx <= $past(last_idx));
   // R10: nothing moves without a sample enable
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |=> $stable(env_idx) && $stable(ph_idx));

endmodule

// File: rtl/sidetone_serializer.sv
module sidetone_serializer #(
   parameter int SLOT_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [SLOT_W-1:0]               word,
   output logic                            ser_out,
   output logic [$clog2(2*SLOT_W)-1:0]     frame_pos
);

   localparam int FP_W      = $clog2(2 * SLOT_W);
   localparam int SLOT_BITS = $clog2(SLOT_W);

   if (SLOT_W < 4 || 2 ** SLOT_BITS != SLOT_W) begin : g_bad_cfg
      $error("sidetone_serializer: slot width must be a power of two");
   end

   logic [FP_W-1:0]   cnt;
   logic [SLOT_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         shreg <= '0;
      end else begin
         cnt <= cnt + FP_W'(1);
         if (cnt[SLOT_BITS-1:0] == '0) shreg <= word;
         else                          shreg <= {shreg[SLOT_W-2:0], 1'b0};
      end
   end

   assign ser_out   = shreg[SLOT_W-1];
   assign frame_pos = cnt;

   // R3: a slot start puts the stored MSB on the line next cycle
   a_r3_slot_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[SLOT_BITS-1:0] == '0) |=> ser_out == $past(word[SLOT_W-1]));

endmodule

// File: rtl/sidetone_gen.sv
module sidetone_gen #(
   parameter int DATA_W    = 16,
   parameter int BASE_LEN  = 80,
   parameter int SIN_AMP   = 32767,
   parameter int ENV_W     = 9,
   parameter int ENV_TOP   = 32766,
   parameter int SLOT_W    = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        key_in,
   input  logic                        smp_en,
   input  logic [1:0]                  period_sel,
   output logic                        ser_out,
   output logic [$clog2(2*SLOT_W)-1:0] frame_pos
);

   localparam int IDX_W     = $clog2(BASE_LEN + 2);
   localparam int PROD_W    = 2 * DATA_W;
   localparam int SLOT_BITS = $clog2(SLOT_W);

   if (SLOT_W != PROD_W) begin : g_bad_cfg
      $error("sidetone_gen: slot width must equal twice the sample width");
   end

   logic [ENV_W-1:0]         env_idx;
   logic [IDX_W-1:0]         ph_idx;
   logic [IDX_W-1:0]         last_idx;
   logic signed [DATA_W-1:0] sine_val;
   logic signed [DATA_W-1:0] gain_val;
   logic signed [PROD_W-1:0] prod;
   logic [SLOT_W-1:0]        word_q;

   sidetone_ctrl #(.ENV_W(ENV_W), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .key(key_in),
      .last_idx(last_idx), .env_idx(env_idx), .ph_idx(ph_idx)
   );

   sidetone_sine_rom #(.DATA_W(DATA_W), .BASE_LEN(BASE_LEN), .AMP(SIN_AMP), .IDX_W(IDX_W)) u_sine (
      .len_sel(period_sel), .idx(ph_idx), .sample(sine_val), .last_idx(last_idx)
   );

   sidetone_env_rom #(.DATA_W(DATA_W), .ENV_W(ENV_W), .TOP(ENV_TOP)) u_env (
      .idx(env_idx), .gain(gain_val)
   );

   assign prod = PROD_W'(sine_val) * PROD_W'(gain_val);

   // Holding register: product of the pre-update indices, doubled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q <= '0;
      else if (smp_en) word_q <= SLOT_W'(prod <<< 1);
   end

   sidetone_serializer #(.SLOT_W(SLOT_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .word(word_q), .ser_out(ser_out), .frame_pos(frame_pos)
   );

   // R4: the last bit of every slot is zero
   a_r4_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_pos[SLOT_BITS-1:0] == '0) |-> !ser_out);
   // R11: a sample taken at zero gain stores a zero word
   a_r11_silent_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && env_idx == '0) |=> word_q == '0);

endmodule

// File: tb/sim_sidetone_gen.sv
module sim_sidetone_gen;

   localparam int  CLK_PERIOD = 10;
   localparam int  WD_CYCLES  = 180000;
   localparam real PI_R       = 3.14159265358979;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_in = 1'b0;
   logic       smp_en = 1'b0;
   logic [1:0] period_sel = 2'b00;
   logic       ser_out;
   logic [5:0] frame_pos;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  en_run   = 1'b1;

   // Reference state: indices and the pending (stored) word's factors
   int  env_m = 0;
   int  ph_m  = 0;
   int  pend_e = 0;
   int  pend_s = 0;

   sidetone_gen u0 (
      .clk(clk), .rst_n(rst_n), .key_in(key_in), .smp_en(smp_en),
      .period_sel(period_sel), .ser_out(ser_out), .frame_pos(frame_pos)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // Sample enable one cycle before every frame start
   initial begin
      forever begin
         @(negedge clk);
         smp_en = en_run && rst_n && (frame_pos == 6'd63);
      end
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   function automatic int rnd(input real x);
      return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
   endfunction

   function automatic int len_of(input logic [1:0] s);
      return (s == 2'b01) ? 79 : ((s == 2'b10) ? 81 : 80);
   endfunction

   function automatic int env_exp(input int k);
      if (k == 0) return 0;
      if (k == 511) return 32766;
      return rnd(32766.0 * (1.0 - $cos(PI_R * k / 511.0)) / 2.0);
   endfunction

   function automatic int sine_exp(input int i, input int n);
      if (i >= n) return 0;
      return rnd(32767.0 * $sin(2.0 * PI_R * i / n));
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Collect one frame, compare it with the reference, then step the reference
   task automatic grab(input bit paused);
      logic [31:0] lw;
      logic [31:0] rw;
      bit          pos_ok;
      longint      got;
      longint      want;
      longint      tol;
      int          env_n;
      int          len;
      lw = '0;
      rw = '0;
      pos_ok = 1'b1;
      do @(negedge clk); while (frame_pos != 6'd1);
      for (int b = 0; b < 64; b++) begin
         if (b > 0) @(negedge clk);
         if (frame_pos != 6'((b + 1) % 64)) pos_ok = 1'b0;
         if (b < 32) lw = {lw[30:0], ser_out};
         else        rw = {rw[30:0], ser_out};
      end
      check(pos_ok, "R2 frame_pos sequence", longint'(frame_pos), 0);
      check(lw == rw, "R3 left/right slots", longint'(rw), longint'(lw));
      check(lw[0] == 1'b0, "R4 slot lsb", longint'(lw[0]), 0);
      got  = longint'($signed(lw)) >>> 1;
      want = longint'(pend_e) * longint'(pend_s);
      if (pend_e == 0) begin
         check(lw == 32'd0, "R9 silent word", longint'($signed(lw)), 0);
      end else begin
         tol = 2 * longint'(pend_e < 0 ? -pend_e : pend_e)
             + 2 * longint'(pend_s < 0 ? -pend_s : pend_s) + 4;
         check((got - want <= tol) && (want - got <= tol), "R5 tone sample", got, want);
         if (pend_e == 32766)
            check(got % 32766 == 0, "R7 full gain exact", got, want);
      end
      if (!paused) begin
         len    = len_of(period_sel);
         pend_e = env_exp(env_m);
         pend_s = sine_exp(ph_m, len);
         if (key_in) env_n = (env_m == 511) ? 511 : env_m + 1;
         else        env_n = (env_m == 0) ? 0 : env_m - 1;
         ph_m  = (env_n == 0) ? 0 : ((ph_m >= len - 1) ? 0 : ph_m + 1);
         env_m = env_n;
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(ser_out == 1'b0, "R1 ser_out in reset", longint'(ser_out), 0);
      check(frame_pos == 6'd0, "R1 frame_pos in reset", longint'(frame_pos), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) grab(1'b0);
      check(env_m == 0 && ph_m == 0, "R1 idle after reset", env_m, 0);
   endtask

   task automatic t_attack();
      period_sel = 2'b00;
      key_in = 1'b1;
      grab(1'b0);
      // R11: first keyed frame still carries the zero-gain word
      check(pend_e == 0, "R11 capture before update", pend_e, 0);
      grab(1'b0);
      check(pend_e != 0 || env_exp(1) == 0, "R11 gain follows one frame later", pend_e, env_exp(1));
      for (int i = 0; i < 528; i++) grab(1'b0);
      check(env_m == 511, "R7 attack reaches top", env_m, 511);
   endtask

   task automatic t_sustain();
      for (int i = 0; i < 100; i++) grab(1'b0);
      check(pend_e == 32766, "R7 sustained gain", pend_e, 32766);
   endtask

   task automatic t_pause();
      en_run = 1'b0;
      for (int i = 0; i < 3; i++) grab(1'b1);
      check(1'b1, "R10 paused frames compared above", 0, 0);
      en_run = 1'b1;
   endtask

   task automatic t_release();
      key_in = 1'b0;
      for (int i = 0; i < 530; i++) grab(1'b0);
      check(env_m == 0, "R8 release reaches zero", env_m, 0);
      check(ph_m == 0, "R9 phase back at zero", ph_m, 0);
   endtask

   task automatic t_lengths();
      period_sel = 2'b01;
      key_in = 1'b1;
      for (int i = 0; i < 200; i++) grab(1'b0);
      check(ph_m < 79, "R6 short table range", ph_m, 78);
      period_sel = 2'b10;
      for (int i = 0; i < 200; i++) grab(1'b0);
      check(ph_m < 81, "R6 long table range", ph_m, 80);
   endtask

   initial begin
      t_reset();
      t_attack();
      t_sustain();
      t_pause();
      t_release();
      t_lengths();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule